// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer driven through a small 16-bit register port. Software programs an 8-bit timeout field in half-second steps and sets a one-way enable bit. After that it must keep the countdown alive by writing a two-word key sequence to a service register. If the countdown runs out first, the block raises a reset request for a fixed number of clock cycles. It also latches a timeout cause bit that survives a block reset and is cleared only by power-on reset.

A built-in prescaler divides the system clock into half-second ticks. The number of clock cycles per tick is a parameter, so a fast value can be used in simulation. The register port is a plain write strobe with a 2-bit register select and a combinational read path. Two reset inputs are provided. The block reset clears everything except the cause bit. The power-on reset clears everything.

Top module: `wdog_keyed_top`

## Requirements
- R1: The register select picks 0 = control, 1 = service, 2 = status. Service and select 3 read as 0x0000. Status is read-only: bit 1 is the timeout cause and every other bit reads 0. A write to status changes nothing.
- R2: In the control register, bits 15:8 hold the timeout field and bits 7, 4, 3, 1 and 0 are plain writable flags. All of these read back as written, and bits 6 and 5 read 0.
- R3: Control bit 2 is the enable. Writing 1 sets it. Writing 0 while it is set leaves it set. Only a block reset or power-on reset clears it.
- R4: With a timeout field F and no valid refresh, the reset request rises exactly (F+1)*TICK_CYCLES clock edges after the write edge that enables the block or the edge of the last valid refresh.
- R5: A valid refresh is a service write of 0x5555 followed by a service write of 0xAAAA. It reloads the countdown from the timeout field and restarts the tick phase, so steady servicing inside the window never produces a reset request.
- R6: After a 0x5555, any service write other than 0xAAAA returns the checker to waiting for 0x5555. This includes a second 0x5555. A 0xAAAA that does not directly follow an accepted 0x5555 does not refresh.
- R7: While the enable is clear, the countdown holds at the timeout field and the reset request stays low.
- R8: On expiry the reset request is high for exactly PULSE_CYCLES consecutive cycles. The countdown then restarts from the timeout field.
- R9: Expiry sets the status cause bit. The bit survives a block reset and is cleared only by power-on reset.
- R10: A timeout field of 0 gives the minimum window of one tick (TICK_CYCLES edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, clears all state |
| rst_n | input | 1 | Asynchronous active-low block reset, keeps the cause bit |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_sel | input | 2 | Register select: 0 control, 1 service, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data of the selected register |
| wdog_rst_req | output | 1 | Reset request, high for PULSE_CYCLES cycles on expiry |

## Verification
A valid refresh and the expiry tick can fall on the same clock edge. The bench provokes this by timing the closing 0xAAAA of a key pair onto the exact edge where the countdown would otherwise expire. The refresh must win: the reset request stays low, and the next deadline is counted from that refresh edge. A cycle-by-cycle reference model judges every other cycle as well, comparing the reset request and the read data of the selected register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned REG_W = 16;
  localparam int unsigned TO_W  = 8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SVC  = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  localparam int unsigned      EN_BIT     = 2;
  localparam int unsigned      CAUSE_BIT  = 1;
  localparam logic [REG_W-1:0] FLAG_MASK  = 16'h009B;
  localparam logic [REG_W-1:0] FIELD_MASK = 16'hFF00;
  localparam logic [REG_W-1:0] EN_MASK    = 16'h0004;

  typedef enum logic {
    KS_WAIT_ARM  = 1'b0,
    KS_WAIT_FIRE = 1'b1
  } key_state_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/wdog_keycheck.sv
module wdog_keycheck
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_we,
  input  logic [REG_W-1:0] svc_data,
  output logic             refresh
);

  key_state_e state_q;
  key_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    refresh  = 1'b0;
    state_en = svc_we;
    if (svc_we) begin
      case (state_q)
        KS_WAIT_ARM: begin
          state_d = (svc_data == KEY_ARM) ? KS_WAIT_FIRE : KS_WAIT_ARM;
        end
        KS_WAIT_FIRE: begin
          state_d = KS_WAIT_ARM;
          refresh = (svc_data == KEY_FIRE);
        end
        default: state_d = KS_WAIT_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_WAIT_ARM;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  AST_ARM_ON_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && state_q == KS_WAIT_ARM && svc_data == KEY_ARM) |=> state_q == KS_WAIT_FIRE); // R5

  AST_SECOND_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && state_q == KS_WAIT_FIRE) |=> state_q == KS_WAIT_ARM); // R6

  AST_IDLE_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_WAIT_ARM) |-> !refresh); // R6

  AST_OTHER_WRITES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_we |=> $stable(state_q)); // R6

endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_CYCLES  = 16384,
  parameter int unsigned PULSE_CYCLES = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [TO_W-1:0] timeout,
  input  logic            refresh,
  output logic            expire,
  output logic            rst_req
);

  localparam int unsigned PW  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int unsigned PLW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PLW-1:0] PULSE_INIT = PLW'(PULSE_CYCLES);

  logic            tick;
  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] cnt_d;
  logic            cnt_en;
  logic [PLW-1:0]  pulse_q;
  logic [PLW-1:0]  pulse_d;
  logic            pulse_en;

  // Half-second tick generator; a single-cycle tick needs no counter.
  generate
    if (TICK_CYCLES > 1) begin : g_pre
      localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYCLES - 1);
      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;
      logic          pre_wrap;

      always_comb begin
        pre_wrap = (pre_q == PRE_LAST);
        if (!enable || refresh || pre_wrap) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign tick = enable && !refresh && pre_wrap;

      AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST); // R4

      AST_PRE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> pre_q == '0); // R7
    end else begin : g_nopre
      assign tick = enable && !refresh;
    end
  endgenerate

  // Countdown: reload while idle, on refresh and on expiry.
  always_comb begin
    expire = tick && (cnt_q == '0);
    cnt_en = 1'b1;
    if (!enable || refresh || expire) begin
      cnt_d = timeout;
    end else if (tick) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Reset request stretcher.
  always_comb begin
    pulse_en = 1'b1;
    if (expire) begin
      pulse_d = PULSE_INIT;
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - 1'b1;
    end else begin
      pulse_d  = pulse_q;
      pulse_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
    end
  end

  assign rst_req = (pulse_q != '0);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt_q == $past(timeout)); // R7

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !rst_req); // R7

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - TO_W'(1)); // R4

  AST_REFRESH_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> cnt_q == $past(timeout)); // R5

  AST_REQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(expire)); // R8

  AST_REQ_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PULSE_INIT); // R8

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             expire,
  output logic [REG_W-1:0] reg_rdata,
  output logic             svc_we,
  output logic             enable,
  output logic [TO_W-1:0]  timeout_ld
);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_we;
  logic             cause_q;
  logic             cause_d;
  logic             cause_en;

  always_comb begin
    ctrl_we = reg_we && (reg_sel == SEL_CTRL);
    svc_we  = reg_we && (reg_sel == SEL_SVC);
    ctrl_d  = (reg_wdata & (FIELD_MASK | FLAG_MASK))
            | (ctrl_q & EN_MASK)
            | (reg_wdata & EN_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Cause bit lives in the power-on domain only.
  always_comb begin
    cause_en = expire;
    cause_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  always_comb begin
    enable     = ctrl_q[EN_BIT];
    timeout_ld = ctrl_we ? reg_wdata[15:8] : ctrl_q[15:8];
    reg_rdata  = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_STAT: reg_rdata[CAUSE_BIT] = cause_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> enable); // R3

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    cause_q |=> cause_q); // R9

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    expire |=> cause_q); // R9

  AST_CTRL_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q[6:5] == 2'b00); // R2

endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_CYCLES  = 16384,
  parameter int unsigned PULSE_CYCLES = 32
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wdog_rst_req
);

  logic            blk_arst_n;
  logic            blk_rst_n;
  logic            por_rst_n;
  logic            svc_we;
  logic            refresh;
  logic            enable;
  logic [TO_W-1:0] timeout_ld;
  logic            expire;

  assign blk_arst_n = por_n & rst_n;

  wdog_rst_sync u_blk_sync (
    .clk    (clk),
    .arst_n (blk_arst_n),
    .srst_n (blk_rst_n)
  );

  wdog_rst_sync u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_rst_n)
  );

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (blk_rst_n),
    .por_n      (por_rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .expire     (expire),
    .reg_rdata  (reg_rdata),
    .svc_we     (svc_we),
    .enable     (enable),
    .timeout_ld (timeout_ld)
  );

  wdog_keycheck u_keys (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .svc_we   (svc_we),
    .svc_data (reg_wdata),
    .refresh  (refresh)
  );

  wdog_timebase #(
    .TICK_CYCLES  (TICK_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_time (
    .clk     (clk),
    .rst_n   (blk_rst_n),
    .enable  (enable),
    .timeout (timeout_ld),
    .refresh (refresh),
    .expire  (expire),
    .rst_req (wdog_rst_req)
  );

endmodule

// File: tb/sim_wdog_keyed_top.sv
module sim_wdog_keyed_top;

  localparam int T = 4;
  localparam int P = 3;

  logic        clk;
  logic        por_n;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        wdog_rst_req;

  int    checks;
  int    fails;
  string cur_req;

  wdog_keyed_top #(.TICK_CYCLES(T), .PULSE_CYCLES(P)) u0 (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .wdog_rst_req (wdog_rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model.
  logic [15:0] m_ctrl;
  bit          m_armed;
  int          m_pre;
  int          m_cnt;
  int          m_pulse;
  bit          m_cause;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n || !rst_n) begin
      m_ctrl  <= '0;
      m_armed <= 1'b0;
      m_pre   <= 0;
      m_cnt   <= 0;
      m_pulse <= 0;
      if (!por_n) m_cause <= 1'b0;
    end else begin
      bit wr_c, wr_s, fresh, en, fired;
      int ld, pre, cnt;
      wr_c  = reg_we && reg_sel == 2'd0;
      wr_s  = reg_we && reg_sel == 2'd1;
      fresh = wr_s && m_armed && reg_wdata == 16'hAAAA;
      en    = m_ctrl[2];
      ld    = wr_c ? int'(reg_wdata[15:8]) : int'(m_ctrl[15:8]);
      pre   = m_pre;
      cnt   = m_cnt;
      fired = 1'b0;
      if (!en || fresh) begin
        pre = 0;
        cnt = ld;
      end else if (pre == T - 1) begin
        pre = 0;
        if (cnt == 0) begin
          fired = 1'b1;
          cnt   = ld;
        end else begin
          cnt = cnt - 1;
        end
      end else begin
        pre = pre + 1;
      end
      m_pre <= pre;
      m_cnt <= cnt;
      if (fired) m_pulse <= P;
      else if (m_pulse > 0) m_pulse <= m_pulse - 1;
      if (fired) m_cause <= 1'b1;
      if (wr_s) m_armed <= !m_armed && reg_wdata == 16'h5555;
      if (wr_c) m_ctrl <= (reg_wdata & 16'hFF9B) | (m_ctrl & 16'h0004) | (reg_wdata & 16'h0004);
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] s);
    case (s)
      2'd0:    return m_ctrl;
      2'd2:    return {14'd0, m_cause, 1'b0};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    #2;
    if (por_n && rst_n) begin
      chk({cur_req, " rst_req"}, {15'd0, wdog_rst_req}, {15'd0, m_pulse > 0});
      chk({cur_req, " rdata"}, reg_rdata, m_read(reg_sel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_we    = 1'b1;
    reg_sel   = s;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [15:0] exp);
    reg_sel = s;
    #1;
    chk(req, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic svc_ok();
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'hAAAA);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k;
    int n;
    checks    = 0;
    fails     = 0;
    cur_req   = "R1";
    por_n     = 1'b0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_sel   = 2'd0;
    reg_wdata = '0;
    idle(3);
    por_n = 1'b1;
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    rd("R1 ctrl reset", 2'd0, 16'h0000);
    rd("R1 status reset", 2'd2, 16'h0000);
    rd("R1 service reads zero", 2'd1, 16'h0000);
    chk("R1 no request after reset", {15'd0, wdog_rst_req}, 16'd0);

    // R2: flags and field, enable clear
    cur_req = "R2";
    wr(2'd0, 16'h12FB);
    rd("R2 ctrl readback", 2'd0, 16'h129B);
    cur_req = "R7";
    idle(20);
    chk("R7 disabled no request", {15'd0, wdog_rst_req}, 16'd0);

    // R5: steady servicing, field 2 (12 cycles)
    cur_req = "R5";
    wr(2'd0, 16'h0204);
    rd("R3 enable set", 2'd0, 16'h0204);
    for (int i = 0; i < 5; i++) begin
      idle(6);
      svc_ok();
    end
    chk("R5 serviced no request", {15'd0, wdog_rst_req}, 16'd0);

    // R6: broken sequences, then R4 deadline from last good refresh
    cur_req = "R6";
    k = 0;
    wr(2'd1, 16'hAAAA); k++;
    wr(2'd1, 16'h5555); k++;
    wr(2'd1, 16'h1234); k++;
    wr(2'd1, 16'hAAAA); k++;
    wr(2'd1, 16'h5555); k++;
    wr(2'd1, 16'h5555); k++;
    wr(2'd1, 16'hAAAA); k++;
    while (!wdog_rst_req && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R4/R6 expiry edge after bad keys", 16'(k), 16'(3 * T));

    // R8: pulse length
    cur_req = "R8";
    n = 0;
    while (wdog_rst_req && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R8 request length", 16'(n), 16'(P));
    rd("R9 cause set", 2'd2, 16'h0002);

    // Refresh on the exact expiry edge
    cur_req = "R5";
    svc_ok();
    idle(3 * T - 2);
    wr(2'd1, 16'h5555);
    wr(2'd1, 16'hAAAA);
    k = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R5 refresh beats expiry", {15'd0, wdog_rst_req}, 16'd0);
      @(negedge clk);
      k++;
    end
    cur_req = "R4";
    while (!wdog_rst_req && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R4 deadline from coincident refresh", 16'(k), 16'(3 * T));
    idle(P + 1);

    // R3: enable cannot be cleared
    cur_req = "R3";
    wr(2'd0, 16'h0200);
    rd("R3 enable sticky", 2'd0, 16'h0204);

    // R1: status is read-only
    cur_req = "R1";
    wr(2'd2, 16'h0000);
    rd("R1 status write ignored", 2'd2, 16'h0002);

    // R9: block reset keeps cause
    cur_req = "R9";
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    rd("R3 block reset clears enable", 2'd0, 16'h0000);
    rd("R9 cause survives block reset", 2'd2, 16'h0002);
    chk("R9 no request after block reset", {15'd0, wdog_rst_req}, 16'd0);

    // R10: minimum timeout
    cur_req = "R10";
    wr(2'd0, 16'h0004);
    k = 0;
    while (!wdog_rst_req && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk("R10 minimum window", 16'(k), 16'(T));
    idle(P + 2);

    // R9: power-on reset clears cause
    cur_req = "R9";
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    idle(4);
    rd("R9 power-on clears cause", 2'd2, 16'h0000);
    rd("R3 power-on clears ctrl", 2'd0, 16'h0000);

    summary();
    $finish;
  end

endmodule